// File: doc/BRIEF.md
# Modem Line Status Tracker

This block watches the four active-low modem handshake inputs of one serial channel: clear-to-send, data-set-ready, ring indicator and carrier detect. Each pin is synchronized into the core clock domain. The block then presents the active level of each line as a status bit, which is high when the line is asserted. For each line it also holds a sticky change flag. Software reads the status byte through a single read strobe, and that read clears the flags. While any flag is set and the modem-status interrupt is enabled, an interrupt request is raised.

For self-test, a loopback input takes the status bits from four modem-control register bits instead of the pins. The switch into or out of loopback is treated like any other movement of the effective line levels, so it can set change flags.

Top module: `modem_status_tracker`

## Requirements
- R1: After reset the status byte reads 0x00 while all pins are high, and the interrupt output is 0.
- R2: Outside loopback, status bits 4, 5, 6 and 7 are the inverted synchronized levels of the CTS, DSR, RI and CD pins. A pin change appears two clock edges after the pin moves.
- R3: Change flags for CTS (bit 0), DSR (bit 1) and CD (bit 3) set on any change of the matching effective line level. They set one edge after the status bit changes, which is three edges after a pin change.
- R4: The RI change flag (bit 2) sets only when the RI pin goes from 0 to 1, at the end of ringing. A 1-to-0 pin change leaves it clear.
- R5: A flag stays set until a read. The status byte is valid in the cycle the read strobe is high, and all four flags clear at that clock edge.
- R6: A change that is detected at the same edge as a read leaves its flag set.
- R7: The interrupt output is 1 exactly when the interrupt enable is 1 and at least one change flag is set. It follows the enable in the same cycle.
- R8: In loopback, status bits 4, 5, 6 and 7 equal control bits 0 (RTS), 1 (DTR), 2 and 3, with no register delay. The pins have no effect.
- R9: Entering or leaving loopback counts as a change of the effective levels and sets flags under the rules of R3 and R4, one edge later.
- R10: In loopback, a change of a control bit sets its flag one edge later, and control bit 2 sets the RI flag only when it falls from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctsN | input | 1 | Clear-to-send pin, active low |
| dsrN | input | 1 | Data-set-ready pin, active low |
| riN | input | 1 | Ring-indicator pin, active low |
| cdN | input | 1 | Carrier-detect pin, active low |
| loopEn | input | 1 | Loopback select |
| ctrlBits | input | 4 | Modem-control bits: 0 RTS, 1 DTR, 2 and 3 auxiliary |
| msIntEn | input | 1 | Modem-status interrupt enable |
| rdStb | input | 1 | Status register read strobe |
| statusOut | output | 8 | Bits 7:4 line levels, bits 3:0 change flags |
| msIrq | output | 1 | Modem-status interrupt request |

## Verification
Each result has its own latency. A pin change reaches the upper status nibble two edges later and a change flag three edges later. In loopback, the status moves in the same cycle and the flag one edge later. The flag clear lands on the edge that ends the read cycle, and the interrupt follows the enable and the flags with no delay. The bench drives inputs on falling edges and waits the exact number of rising edges before each directed check. Its reference model keeps a two-deep history queue of pin samples, which reproduces the synchronizer delay without copying its flops. It compares every output 3 ns after each rising edge, so the registered results are settled by the time they are read.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LINES = 4;
  // Lines whose change flag only fires when the active level falls (ring ends).
  localparam logic [LINES-1:0] TRAIL_ONLY = 4'b0100;

  typedef struct packed {
    logic [LINES-1:0] setMask;
    logic             clearAll;
  } msrStrobe_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= RESET_VAL;
        else        chain[0] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= RESET_VAL;
        else        chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] syncN,
  input  logic             loopEn,
  input  logic [LINES-1:0] ctrlBits,
  input  logic             rdStb,
  output logic [LINES-1:0] actLvl,
  output msrStrobe_t       strobe
);
  logic [LINES-1:0] prevLvl;
  logic [LINES-1:0] chg;

  // Effective active-high levels: control bits in loopback, inverted pins otherwise.
  assign actLvl = loopEn ? ctrlBits : ~syncN;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prevLvl <= '0;
    else        prevLvl <= actLvl;

  for (genvar g = 0; g < LINES; g++) begin : g_det
    if (TRAIL_ONLY[g]) begin : g_trail
      assign chg[g] = prevLvl[g] & ~actLvl[g];
    end else begin : g_any
      assign chg[g] = prevLvl[g] ^ actLvl[g];
    end
  end

  assign strobe.setMask  = chg;
  assign strobe.clearAll = rdStb;
endmodule

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  msrStrobe_t       strobe,
  input  logic [LINES-1:0] actLvl,
  output logic [7:0]       statusByte,
  output logic             anyFlag
);
  logic [LINES-1:0] flagReg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flagReg <= '0;
    else        flagReg <= (flagReg & ~{LINES{strobe.clearAll}}) | strobe.setMask;

  assign statusByte = {actLvl, flagReg};
  assign anyFlag    = |flagReg;

  // R5: without a read, no flag ever drops.
  a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.clearAll |=> (($past(flagReg) & ~flagReg) == '0));

  // R4: the ring flag rises only after the active ring level has fallen to 0.
  a_r4_ri_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flagReg[2]) |-> !$past(actLvl[2]));
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       riN,
  input  logic       cdN,
  input  logic       loopEn,
  input  logic [3:0] ctrlBits,
  input  logic       msIntEn,
  input  logic       rdStb,
  output logic [7:0] statusOut,
  output logic       msIrq
);
  logic [LINES-1:0] syncN;
  logic [LINES-1:0] actLvl;
  msrStrobe_t       strobe;
  logic             anyFlag;

  msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RESET_VAL('1)) i_sync (
    .clk(clk), .rst_n(rst_n), .din({cdN, riN, dsrN, ctsN}), .dout(syncN)
  );

  msr_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .syncN(syncN), .loopEn(loopEn),
    .ctrlBits(ctrlBits), .rdStb(rdStb), .actLvl(actLvl), .strobe(strobe)
  );

  msr_datapath i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .actLvl(actLvl),
    .statusByte(statusOut), .anyFlag(anyFlag)
  );

  assign msIrq = msIntEn & anyFlag;

  // R7: no request while the enable is off.
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !msIntEn |-> !msIrq);

  // R7: a request always has a visible flag behind it.
  a_r7_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    msIrq |-> (statusOut[3:0] != 4'b0000));

  // R8: in steady loopback with steady control bits, pin activity cannot move the levels.
  a_r8_loop_ignores_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (loopEn && $stable(loopEn) && $stable(ctrlBits)) |-> $stable(statusOut[7:4]));
endmodule

// File: tb/test_modem_status_tracker.sv
module test_modem_status_tracker;
  logic clk = 0, rst_n = 0;
  logic ctsN = 1, dsrN = 1, riN = 1, cdN = 1;
  logic loopEn = 0, msIntEn = 0, rdStb = 0;
  logic [3:0] ctrlBits = 4'b0000;
  logic [7:0] statusOut;
  logic msIrq;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modem_status_tracker i_modem_status_tracker (
    .clk(clk), .rst_n(rst_n), .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .cdN(cdN),
    .loopEn(loopEn), .ctrlBits(ctrlBits), .msIntEn(msIntEn), .rdStb(rdStb),
    .statusOut(statusOut), .msIrq(msIrq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: pin history queue stands in for synchronizer delay.
  logic [3:0] hist[$] = '{4'hF, 4'hF};
  logic [3:0] prevM = 0, flagsM = 0;

  function automatic logic [3:0] effLvl();
    return loopEn ? ctrlBits : ~hist[0];
  endfunction

  always @(posedge clk) begin
    logic [3:0] a, d;
    if (!rst_n) begin
      hist = '{4'hF, 4'hF}; prevM = 0; flagsM = 0;
    end else begin
      a = effLvl();
      d = ((prevM ^ a) & 4'b1011) | (prevM & ~a & 4'b0100);
      flagsM = (rdStb ? 4'b0000 : flagsM) | d;
      prevM = a;
      hist.push_back({cdN, riN, dsrN, ctsN});
      void'(hist.pop_front());
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk(loopEn ? "R8 levels" : "R2 levels", statusOut[7:4], effLvl());
      chk("R3 flags", statusOut[3:0], flagsM);
      chk("R7 irq", msIrq, msIntEn && (flagsM != 0));
    end
  end

  task automatic readPulse();
    rdStb = 1;
    @(negedge clk);
    rdStb = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", statusOut, 8'h00);
    chk("R1 irq", msIrq, 0);
    rst_n = 1;
    @(negedge clk);
    #1 chk("R1 status after release", statusOut, 8'h00);

    ctsN = 0;
    repeat (2) @(negedge clk);
    #1 chk("R2 cts level", statusOut[4], 1);
    chk("R3 cts flag not yet", statusOut[0], 0);
    @(negedge clk);
    #1 chk("R3 cts flag", statusOut[0], 1);
    chk("R7 irq disabled", msIrq, 0);
    msIntEn = 1;
    #1 chk("R7 irq enabled", msIrq, 1);

    rdStb = 1;
    #1 chk("R5 read value", statusOut[3:0], 4'b0001);
    @(negedge clk);
    rdStb = 0;
    #1 chk("R5 cleared", statusOut[3:0], 4'b0000);
    chk("R7 irq dropped", msIrq, 0);

    riN = 0;
    repeat (3) @(negedge clk);
    #1 chk("R4 ring level", statusOut[6], 1);
    chk("R4 leading edge no flag", statusOut[2], 0);
    riN = 1;
    repeat (3) @(negedge clk);
    #1 chk("R4 trailing edge flag", statusOut[2], 1);
    readPulse();

    dsrN = 0; cdN = 0;
    repeat (3) @(negedge clk);
    #1 chk("R3 dsr cd flags", statusOut[3:0], 4'b1010);
    readPulse();

    cdN = 1;
    repeat (2) @(negedge clk);
    rdStb = 1;
    @(negedge clk);
    rdStb = 0;
    #1 chk("R6 change survives read", statusOut[3:0], 4'b1000);
    readPulse();

    ctrlBits = 4'b0101; loopEn = 1;
    #1 chk("R8 loop map", statusOut[7:4], 4'b0101);
    @(negedge clk);
    #1 chk("R9 loop entry flags", statusOut[3:0], 4'b0010);
    ctsN = 1; dsrN = 1; riN = 0;
    repeat (3) @(negedge clk);
    #1 chk("R8 pins ignored", statusOut, 8'h52);
    riN = 1;
    readPulse();
    ctrlBits = 4'b0001;
    @(negedge clk);
    #1 chk("R10 ctrl ring trailing", statusOut[3:0], 4'b0100);
    readPulse();
    loopEn = 0;
    #1 chk("R2 loop exit levels", statusOut[7:4], 4'b0000);
    @(negedge clk);
    #1 chk("R9 loop exit flags", statusOut[3:0], 4'b0001);
    readPulse();

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 5) == 0) ctsN = ~ctsN;
      if ($urandom_range(0, 6) == 0) dsrN = ~dsrN;
      if ($urandom_range(0, 7) == 0) riN = ~riN;
      if ($urandom_range(0, 8) == 0) cdN = ~cdN;
      if ($urandom_range(0, 60) == 0) loopEn = ~loopEn;
      if ($urandom_range(0, 4) == 0) ctrlBits = 4'($urandom);
      if ($urandom_range(0, 30) == 0) msIntEn = ~msIntEn;
      rdStb = ($urandom_range(0, 5) == 0);
    end
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule